// File: doc/BRIEF.md
# Color Palette Memory with Write-Dot Artifact

This block holds the color palette of a tile-based video display processor. A CPU-side write port takes a byte address and a 16-bit word. Only the color-carrying bits of that word are stored: three bits in each of the three low nibbles, with the lowest bit of every nibble cleared. Two registered read ports serve the pixel pipeline. One is a general lookup by entry index. The other returns the background color, chosen by a background-select register value.

The write side is tied to the raster. The block watches the current horizontal slot and vertical line. If a write arrives while the beam is inside the visible picture, the written color replaces the second of the two pixels produced in that slot. This imitates the colored dot that real hardware shows when software updates the palette mid-frame. Writes outside that window only update the memory.

Two mode inputs control the decoding. The extended-mode input selects how the write address is decoded, which palette view the forced pixel is tagged with, and how the background index is formed. The wide-mode input selects the 320-pixel or 256-pixel line width, which sets where the horizontal window ends.

Top module: `pal_ram_artifact`

## Requirements
- R1: Every stored word, and so every word read back on `rd_color` or `bg_color`, equals the written data ANDed with 0x0EEE.
- R2: With `ext_mode`=1 the written entry is `wr_addr` shifted right by one, taken modulo 64.
- R3: With `ext_mode`=0 the written entry is the low 5 bits of `wr_addr` (entries 0 to 31).
- R4: The horizontal part of the artifact window is `hslot` >= 9 and `hslot` < 169 when `wide_mode`=1, or `hslot` < 137 when `wide_mode`=0.
- R5: The vertical part of the window is `vline` < `act_end_line`+`bord_bot`, or `vline` > 512−`bord_top`. The sums and differences are taken without truncation.
- R6: A write inside both windows makes the block do three things one clock later: raise `pix_forced`, drive `pix_out` with the masked written color, and drive `pix_num` with (`hslot`−9)×2+1.
- R7: In any cycle without an in-window write, one clock later `pix_out` equals the `pipe_pix` of that cycle, and `pix_forced` and `pix_num` are 0. The memory is still written.
- R8: During a forced pixel, `pix_legacy_view` is 1 exactly when `ext_mode` was 0 in the write cycle. Otherwise it is 0.
- R9: The background entry is `bg_sel` modulo 64 when `ext_mode`=1, and 16 plus `bg_sel[3:0]` when `ext_mode`=0. `bg_color` shows that entry's stored value one clock later.
- R10: `rd_color` shows the entry selected by `rd_idx` one clock later. A write is visible to a read presented in the following cycle.
- R11: Asynchronous active-low reset clears all entries and drives every output to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ext_mode | input | 1 | 1 = extended address decode and normal palette view; 0 = legacy |
| wide_mode | input | 1 | 1 = 320-pixel lines, 0 = 256-pixel lines |
| wr_en | input | 1 | CPU palette write strobe |
| wr_addr | input | 7 | Write byte address |
| wr_data | input | 16 | Write data before masking |
| hslot | input | 9 | Current horizontal slot |
| vline | input | 9 | Current vertical line |
| act_end_line | input | 9 | First line of the inactive period |
| bord_bot | input | 9 | Bottom border height in lines |
| bord_top | input | 9 | Top border height in lines |
| bg_sel | input | 6 | Background select register value |
| rd_idx | input | 6 | Pixel pipeline read index |
| pipe_pix | input | 16 | Color the pipeline would emit for the slot's second pixel |
| rd_color | output | 16 | Registered read data |
| bg_color | output | 16 | Registered background color |
| pix_out | output | 16 | Slot's second pixel after any artifact override |
| pix_num | output | 10 | Index of the forced pixel, 0 when none |
| pix_forced | output | 1 | The pixel was overridden by a write |
| pix_legacy_view | output | 1 | The forced pixel uses the legacy palette view |

## Verification
Two functions can land on the same clock. One is the memory update, seen later through `rd_color` or `bg_color`. The other is the pixel override, seen at once on `pix_out`. The bench provokes both with random writes mixed into random raster positions. It also walks directed positions one slot and one line on either side of every window edge. In the same clock it reads back the entry it just wrote, so that the override color, the forced pixel number and the read-back value are all compared against a model. Writes that fall outside the window are judged by two checks: `pix_out` must still follow `pipe_pix`, and the new value must still appear on the read port.

// File: rtl/pal_pkg.sv
package pal_pkg;

   typedef enum logic {
      VIEW_NORMAL = 1'b0,
      VIEW_LEGACY = 1'b1
   } pal_view_e;

   function automatic logic [15:0] pal_mask_color(input logic [15:0] raw,
                                                  input logic [15:0] keep);
      return raw & keep;
   endfunction

endpackage

// File: rtl/pal_addr_dec.sv
module pal_addr_dec #(
   parameter int ADDR_W         = 7,
   parameter int ENTRIES        = 64,
   parameter int LEGACY_ENTRIES = 32,
   parameter int LEGACY_BG_BASE = 16,
   localparam int IDX_W         = $clog2(ENTRIES),
   localparam int LIDX_W        = $clog2(LEGACY_ENTRIES)
) (
   input  logic              ext_mode,
   input  logic [ADDR_W-1:0] byte_addr,
   input  logic [IDX_W-1:0]  bg_sel,
   output logic [IDX_W-1:0]  wr_idx,
   output logic [IDX_W-1:0]  bg_idx
);

   localparam logic [IDX_W-1:0] BG_BASE = IDX_W'(LEGACY_BG_BASE);

   generate
      if (ADDR_W < IDX_W + 1) begin : g_bad_addr
         $error("pal_addr_dec: ADDR_W too small for ENTRIES");
      end
      if (LEGACY_ENTRIES > ENTRIES) begin : g_bad_legacy
         $error("pal_addr_dec: legacy palette larger than palette");
      end
   endgenerate

   logic [IDX_W-1:0] ext_idx;
   logic [IDX_W-1:0] leg_idx;
   logic [IDX_W-1:0] leg_bg;

   assign ext_idx = byte_addr[IDX_W:1];

   generate
      if (LIDX_W < IDX_W) begin : g_leg_pad
         assign leg_idx = {{(IDX_W-LIDX_W){1'b0}}, byte_addr[LIDX_W-1:0]};
      end else begin : g_leg_full
         assign leg_idx = byte_addr[IDX_W-1:0];
      end
   endgenerate

   assign leg_bg = BG_BASE + {{(IDX_W-4){1'b0}}, bg_sel[3:0]};

   always_comb begin
      if (ext_mode) begin
         wr_idx = ext_idx;
         bg_idx = bg_sel;
      end else begin
         wr_idx = leg_idx;
         bg_idx = leg_bg;
      end
   end

endmodule

// File: rtl/pal_window.sv
module pal_window #(
   parameter int SLOT_W     = 9,
   parameter int LINE_W     = 9,
   parameter int START_SLOT = 9,
   parameter int WIDE_PIX   = 320,
   parameter int NARROW_PIX = 256,
   localparam int PIX_W     = SLOT_W + 1
) (
   input  logic              wide_mode,
   input  logic [SLOT_W-1:0] hslot,
   input  logic [LINE_W-1:0] vline,
   input  logic [LINE_W-1:0] act_end_line,
   input  logic [LINE_W-1:0] bord_bot,
   input  logic [LINE_W-1:0] bord_top,
   output logic              in_window,
   output logic [PIX_W-1:0]  pix_idx
);

   localparam int WIDE_END   = START_SLOT + WIDE_PIX / 2;
   localparam int NARROW_END = START_SLOT + NARROW_PIX / 2;

   generate
      if (WIDE_END >= (1 << SLOT_W) || NARROW_END >= (1 << SLOT_W)) begin : g_bad_slot
         $error("pal_window: SLOT_W cannot hold the end slot");
      end
      if ((WIDE_PIX % 2) != 0 || (NARROW_PIX % 2) != 0) begin : g_bad_pix
         $error("pal_window: pixel counts must be even");
      end
   endgenerate

   localparam logic [SLOT_W-1:0] START_S  = SLOT_W'(START_SLOT);
   localparam logic [SLOT_W-1:0] WEND_S   = SLOT_W'(WIDE_END);
   localparam logic [SLOT_W-1:0] NEND_S   = SLOT_W'(NARROW_END);
   localparam logic [LINE_W:0]   WRAP_LN  = {1'b1, {LINE_W{1'b0}}};

   logic [SLOT_W-1:0] end_s;
   logic              h_hit;
   logic [LINE_W:0]   bot_lim;
   logic [LINE_W:0]   top_lim;
   logic [LINE_W:0]   vline_x;
   logic              v_hit;
   logic [SLOT_W-1:0] slot_off;

   assign end_s    = wide_mode ? WEND_S : NEND_S;
   assign h_hit    = (hslot >= START_S) && (hslot < end_s);
   assign vline_x  = {1'b0, vline};
   assign bot_lim  = {1'b0, act_end_line} + {1'b0, bord_bot};
   assign top_lim  = WRAP_LN - {1'b0, bord_top};
   assign v_hit    = (vline_x < bot_lim) || (vline_x > top_lim);
   assign slot_off = hslot - START_S;

   assign in_window = h_hit && v_hit;
   assign pix_idx   = {slot_off, 1'b1};

endmodule

// File: rtl/pal_store.sv
module pal_store #(
   parameter int          ENTRIES = 64,
   parameter int          DATA_W  = 16,
   parameter logic [15:0] KEEP    = 16'h0EEE,
   localparam int         IDX_W   = $clog2(ENTRIES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [IDX_W-1:0]  widx,
   input  logic [DATA_W-1:0] wdata,
   input  logic [IDX_W-1:0]  ridx_a,
   input  logic [IDX_W-1:0]  ridx_b,
   output logic [DATA_W-1:0] rdata_a,
   output logic [DATA_W-1:0] rdata_b
);

   generate
      if (ENTRIES != (1 << IDX_W)) begin : g_bad_depth
         $error("pal_store: ENTRIES must be a power of two");
      end
      if (DATA_W != 16) begin : g_bad_width
         $error("pal_store: DATA_W must be 16");
      end
   endgenerate

   logic [DATA_W-1:0] cells [ENTRIES];

   for (genvar e = 0; e < ENTRIES; e++) begin : g_cell
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            cells[e] <= '0;
         end else if (we && (widx == IDX_W'(e))) begin
            cells[e] <= wdata;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rdata_a <= '0;
         rdata_b <= '0;
      end else begin
         rdata_a <= cells[ridx_a];
         rdata_b <= cells[ridx_b];
      end
   end

   p_mask_rd_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (rdata_a & ~KEEP) == '0);
   p_mask_bg_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (rdata_b & ~KEEP) == '0);

endmodule

// File: rtl/pal_ram_artifact.sv
module pal_ram_artifact #(
   parameter int          ENTRIES        = 64,
   parameter int          LEGACY_ENTRIES = 32,
   parameter int          ADDR_W         = 7,
   parameter int          DATA_W         = 16,
   parameter int          SLOT_W         = 9,
   parameter int          LINE_W         = 9,
   parameter int          START_SLOT     = 9,
   parameter int          WIDE_PIX       = 320,
   parameter int          NARROW_PIX     = 256,
   parameter logic [15:0] KEEP           = 16'h0EEE,
   localparam int         IDX_W          = $clog2(ENTRIES),
   localparam int         PIX_W          = SLOT_W + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ext_mode,
   input  logic              wide_mode,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [SLOT_W-1:0] hslot,
   input  logic [LINE_W-1:0] vline,
   input  logic [LINE_W-1:0] act_end_line,
   input  logic [LINE_W-1:0] bord_bot,
   input  logic [LINE_W-1:0] bord_top,
   input  logic [IDX_W-1:0]  bg_sel,
   input  logic [IDX_W-1:0]  rd_idx,
   input  logic [DATA_W-1:0] pipe_pix,
   output logic [DATA_W-1:0] rd_color,
   output logic [DATA_W-1:0] bg_color,
   output logic [DATA_W-1:0] pix_out,
   output logic [PIX_W-1:0]  pix_num,
   output logic              pix_forced,
   output logic              pix_legacy_view
);

   import pal_pkg::*;

   logic [IDX_W-1:0]  wr_idx;
   logic [IDX_W-1:0]  bg_idx;
   logic [DATA_W-1:0] wr_kept;
   logic              in_window;
   logic [PIX_W-1:0]  pix_idx;
   logic              force_now;
   pal_view_e         view_now;
   logic              live_q;

   pal_addr_dec #(
      .ADDR_W         (ADDR_W),
      .ENTRIES        (ENTRIES),
      .LEGACY_ENTRIES (LEGACY_ENTRIES),
      .LEGACY_BG_BASE (LEGACY_ENTRIES / 2)
   ) u_dec (
      .ext_mode  (ext_mode),
      .byte_addr (wr_addr),
      .bg_sel    (bg_sel),
      .wr_idx    (wr_idx),
      .bg_idx    (bg_idx)
   );

   pal_window #(
      .SLOT_W     (SLOT_W),
      .LINE_W     (LINE_W),
      .START_SLOT (START_SLOT),
      .WIDE_PIX   (WIDE_PIX),
      .NARROW_PIX (NARROW_PIX)
   ) u_win (
      .wide_mode    (wide_mode),
      .hslot        (hslot),
      .vline        (vline),
      .act_end_line (act_end_line),
      .bord_bot     (bord_bot),
      .bord_top     (bord_top),
      .in_window    (in_window),
      .pix_idx      (pix_idx)
   );

   assign wr_kept = pal_mask_color(wr_data, KEEP);

   pal_store #(
      .ENTRIES (ENTRIES),
      .DATA_W  (DATA_W),
      .KEEP    (KEEP)
   ) u_store (
      .clk     (clk),
      .rst_n   (rst_n),
      .we      (wr_en),
      .widx    (wr_idx),
      .wdata   (wr_kept),
      .ridx_a  (rd_idx),
      .ridx_b  (bg_idx),
      .rdata_a (rd_color),
      .rdata_b (bg_color)
   );

   assign force_now = wr_en && in_window;
   assign view_now  = ext_mode ? VIEW_NORMAL : VIEW_LEGACY;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pix_out         <= '0;
         pix_num         <= '0;
         pix_forced      <= 1'b0;
         pix_legacy_view <= 1'b0;
         live_q          <= 1'b0;
      end else begin
         live_q     <= 1'b1;
         pix_forced <= force_now;
         if (force_now) begin
            pix_out         <= wr_kept;
            pix_num         <= pix_idx;
            pix_legacy_view <= (view_now == VIEW_LEGACY);
         end else begin
            pix_out         <= pipe_pix;
            pix_num         <= '0;
            pix_legacy_view <= 1'b0;
         end
      end
   end

   p_force_needs_wr_r6: assert property (@(posedge clk) disable iff (!rst_n)
      live_q && pix_forced |-> $past(wr_en));
   p_force_color_r6: assert property (@(posedge clk) disable iff (!rst_n)
      live_q && pix_forced |-> pix_out == ($past(wr_data) & KEEP));
   p_force_hstart_r4: assert property (@(posedge clk) disable iff (!rst_n)
      live_q && pix_forced |-> $past(hslot) >= SLOT_W'(START_SLOT));
   p_pass_through_r7: assert property (@(posedge clk) disable iff (!rst_n)
      live_q && !pix_forced |-> pix_out == $past(pipe_pix) && pix_num == '0);
   p_view_tag_r8: assert property (@(posedge clk) disable iff (!rst_n)
      live_q && pix_forced |-> pix_legacy_view == !$past(ext_mode));
   p_pixnum_odd_r6: assert property (@(posedge clk) disable iff (!rst_n)
      pix_forced |-> pix_num[0]);

endmodule

// File: tb/pal_ram_artifact_bench.sv
`timescale 1ns/100ps
module pal_ram_artifact_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ext_mode = 1'b1, wide_mode = 1'b1, wr_en = 1'b0;
   logic [6:0]  wr_addr = '0;
   logic [15:0] wr_data = '0, pipe_pix = '0;
   logic [8:0]  hslot = '0, vline = '0, act_end_line = 9'd224, bord_bot = 9'd8, bord_top = 9'd11;
   logic [5:0]  bg_sel = '0, rd_idx = '0;
   logic [15:0] rd_color, bg_color, pix_out;
   logic [9:0]  pix_num;
   logic        pix_forced, pix_legacy_view;

   int vectors = 0;
   int fails = 0;
   bit done = 0;
   logic [15:0] model [64];

   always #2.5 clk = ~clk;

   pal_ram_artifact u_pal_ram_artifact (
      .clk(clk), .rst_n(rst_n), .ext_mode(ext_mode), .wide_mode(wide_mode),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .hslot(hslot),
      .vline(vline), .act_end_line(act_end_line), .bord_bot(bord_bot),
      .bord_top(bord_top), .bg_sel(bg_sel), .rd_idx(rd_idx), .pipe_pix(pipe_pix),
      .rd_color(rd_color), .bg_color(bg_color), .pix_out(pix_out),
      .pix_num(pix_num), .pix_forced(pix_forced), .pix_legacy_view(pix_legacy_view)
   );

   function automatic int f_widx(logic [6:0] a, logic ext);
      return ext ? int'(a >> 1) % 64 : int'(a) % 32;
   endfunction

   function automatic int f_bgidx(logic [5:0] s, logic ext);
      return ext ? int'(s) : 16 + int'(s[3:0]);
   endfunction

   function automatic bit f_inwin(int hs, int vl, bit wide, int ae, int bb, int bt);
      int hend;
      hend = wide ? 169 : 137;
      return (hs >= 9) && (hs < hend) && ((vl < ae + bb) || (vl > 512 - bt));
   endfunction

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      vectors++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h time=%0t", req, act, exp, $time);
      end
   endtask

   // One clock: inputs already driven; compute expectations, clock, compare.
   task automatic step();
      bit          frc;
      logic [15:0] e_pix, e_rd, e_bg;
      logic [9:0]  e_num;
      logic        e_view;
      frc    = wr_en && f_inwin(int'(hslot), int'(vline), wide_mode,
                                int'(act_end_line), int'(bord_bot), int'(bord_top));
      e_pix  = frc ? (wr_data & 16'h0EEE) : pipe_pix;
      e_num  = frc ? 10'((int'(hslot) - 9) * 2 + 1) : 10'd0;
      e_view = frc ? !ext_mode : 1'b0;
      e_rd   = model[rd_idx];
      e_bg   = model[f_bgidx(bg_sel, ext_mode)];
      @(posedge clk);
      #1;
      chk("R6/R7 pix_forced", {31'd0, pix_forced}, {31'd0, frc});
      chk("R6/R7 pix_out", {16'd0, pix_out}, {16'd0, e_pix});
      chk("R6 pix_num", {22'd0, pix_num}, {22'd0, e_num});
      chk("R8 view", {31'd0, pix_legacy_view}, {31'd0, e_view});
      chk("R10 rd_color", {16'd0, rd_color}, {16'd0, e_rd});
      chk("R9 bg_color", {16'd0, bg_color}, {16'd0, e_bg});
      if (wr_en) model[f_widx(wr_addr, ext_mode)] = wr_data & 16'h0EEE;
      @(negedge clk);
   endtask

   task automatic drive_wr(logic ext, logic wide, int hs, int vl, logic [6:0] a, logic [15:0] d);
      ext_mode = ext; wide_mode = wide; wr_en = 1'b1;
      hslot = 9'(hs); vline = 9'(vl); wr_addr = a; wr_data = d;
      pipe_pix = 16'hA5A5;
      step();
      wr_en = 1'b0;
   endtask

   initial begin
      #(5.0 * 150000);
      if (!done) begin
         fails++;
         $display("FAIL watchdog expired");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd1234));
      for (int i = 0; i < 64; i++) model[i] = '0;
      repeat (3) @(posedge clk);
      #1;
      // R11 reset state
      chk("R11 rd_color", {16'd0, rd_color}, 32'd0);
      chk("R11 pix_out", {16'd0, pix_out}, 32'd0);
      chk("R11 pix_forced", {31'd0, pix_forced}, 32'd0);
      chk("R11 pix_num", {22'd0, pix_num}, 32'd0);
      @(negedge clk);
      rst_n = 1'b1;
      step();

      // R2 extended decode: byte 0x7F -> entry 63; R1 masking of 0xFFFF
      drive_wr(1'b1, 1'b1, 300, 300, 7'h7F, 16'hFFFF);
      rd_idx = 6'd63; step();
      chk("R1 R2 entry63", {16'd0, rd_color}, 32'h0EEE);
      // R3 legacy decode: byte 0x3F -> entry 31, upper addr bit ignored
      drive_wr(1'b0, 1'b1, 300, 300, 7'h7F, 16'h0246);
      rd_idx = 6'd31; step();
      chk("R3 entry31", {16'd0, rd_color}, 32'h0246);
      // R9 legacy background: 16 + low nibble of 0x2F -> 31
      ext_mode = 1'b0; bg_sel = 6'h2F; step(); step();
      // R4 horizontal edges, wide and narrow
      drive_wr(1'b1, 1'b1, 8, 10, 7'h02, 16'h0111);
      drive_wr(1'b1, 1'b1, 9, 10, 7'h04, 16'h0222);
      drive_wr(1'b1, 1'b1, 168, 10, 7'h06, 16'h0333);
      drive_wr(1'b1, 1'b1, 169, 10, 7'h08, 16'h0444);
      drive_wr(1'b0, 1'b0, 136, 10, 7'h0A, 16'h0555);
      drive_wr(1'b0, 1'b0, 137, 10, 7'h0C, 16'h0666);
      // R5 vertical edges: end 224+8=232, top 512-11=501
      drive_wr(1'b1, 1'b1, 50, 231, 7'h0E, 16'h0888);
      drive_wr(1'b1, 1'b1, 50, 232, 7'h10, 16'h0AAA);
      drive_wr(1'b1, 1'b1, 50, 501, 7'h12, 16'h0CCC);
      drive_wr(1'b1, 1'b1, 50, 502, 7'h14, 16'h0EEE);
      // R7 out-of-window write still lands in memory, R10 read-after-write
      rd_idx = 6'd10;
      drive_wr(1'b1, 1'b1, 200, 100, 7'h14, 16'h0468);
      step();
      chk("R7 R10 memory written", {16'd0, rd_color}, 32'h0468);

      // random mix
      for (int n = 0; n < 4000; n++) begin
         ext_mode     = 1'($urandom_range(0, 1));
         wide_mode    = 1'($urandom_range(0, 1));
         wr_en        = ($urandom_range(0, 99) < 55);
         wr_addr      = 7'($urandom);
         wr_data      = 16'($urandom);
         hslot        = 9'($urandom_range(0, 200));
         vline        = 9'($urandom_range(0, 511));
         if ($urandom_range(0, 19) == 0) begin
            act_end_line = ($urandom_range(0, 1) != 0) ? 9'd240 : 9'd224;
            bord_bot     = 9'($urandom_range(0, 15));
            bord_top     = 9'($urandom_range(0, 15));
         end
         bg_sel       = 6'($urandom);
         rd_idx       = ($urandom_range(0, 3) == 0) ? 6'(f_widx(wr_addr, ext_mode)) : 6'($urandom);
         pipe_pix     = 16'($urandom);
         step();
      end
      wr_en = 1'b0;

      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end

endmodule